// File: doc/BRIEF.md
# DRAM Row-Buffer Command Sequencer

This block turns single-word memory requests into the command stream for one rank of an SDRAM-style device. Each request carries a flat word address. The block splits it into a row, a bank and a column. The row is the top 12 bits, the bank is the 2 bits below it and the column is the low 9 bits, so there are four banks. For every bank the block remembers which row, if any, is currently held open in the row buffer.

A request to the row that is already open is served with a single column command. A request to a closed bank gets an activate, then the column command. A request to a bank that holds a different row first closes that row with a precharge. The minimum gaps are enforced by down-counters in clock cycles:

- precharge to activate,
- activate to column command,
- refresh to the next command.

Read data comes back a fixed CAS latency after the read command and is handed to the requester unchanged. A free-running interval counter raises a refresh request. Once the current sequence has finished, the block closes every open row with one all-bank precharge, issues an auto-refresh and counts every bank as closed. Only then does it accept new requests.

Top module: `rowbuf_sequencer`

## Requirements
- R1: Address fields are row = reqAddr[22:11], bank = reqAddr[10:9] and column = reqAddr[8:0]. An activate drives the row on sdAddr. A read or write drives the column on sdAddr[8:0] with sdAddr[10]=0. Every per-bank command drives the bank on sdBank.
- R2: Commands are encoded on {sdRasN, sdCasN, sdWeN} as follows:
  - 111 no-op
  - 011 activate
  - 101 read
  - 100 write
  - 010 precharge: sdAddr[10]=0 closes the one bank on sdBank, sdAddr[10]=1 closes all banks
  - 001 auto-refresh
- R3: A request to a closed bank is served as follows. The activate appears in the cycle after acceptance. The column command follows exactly T_RCD cycles after the activate, and no precharge is issued.
- R4: A request to a bank holding a different row is served as follows. A precharge to that bank appears in the cycle after acceptance. The activate follows exactly T_RP cycles later, and the column command follows T_RCD cycles after that.
- R5: A request to the open row of its bank produces only its column command, in the cycle after acceptance, with no activate or precharge.
- R6: rspValid is high exactly CAS_LAT cycles after a read command and low in the cycles between. While it is high, rspData equals sdRdata.
- R7: In the cycle of a write command, sdWdata carries the accepted request's write data.
- R8: Every REF_INTERVAL cycles a refresh becomes pending.
  - If any bank is open, an all-bank precharge is issued, then the refresh T_RP cycles later. Otherwise the refresh is issued directly.
  - reqReady returns exactly T_RFC cycles after the refresh.
  - Afterwards every bank is closed.
- R9: reqReady is high only when the block is idle and no refresh is pending. It is low in the cycle after any accepted request.
- R10: After reset the bus shows no-op, reqReady is high, rspValid is low and all banks are closed.
- R11: A refresh that becomes pending while a request is in progress waits until that request's column command has been issued. No refresh or all-bank precharge is inserted inside a request's sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 23 | Flat word address {row, bank, column} |
| reqWdata | input | 16 | Write data |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| rspValid | output | 1 | Read data valid |
| rspData | output | 16 | Read data |
| sdRasN | output | 1 | Active-low row strobe |
| sdCasN | output | 1 | Active-low column strobe |
| sdWeN | output | 1 | Active-low write enable |
| sdBank | output | 2 | Bank select |
| sdAddr | output | 12 | Multiplexed row/column address |
| sdWdata | output | 16 | Write data toward the device |
| sdRdata | input | 16 | Read data from the device |

## Verification
Two functions can fall in the same cycle: the refresh interval counter expiring, and a request being accepted or already walking through its precharge, activate and column steps. To provoke this, the bench streams back-to-back requests that alternate rows in one bank across a full refresh interval, so the expiry lands at an arbitrary point inside a sequence. The bench judges the result in two ways. No request window may contain a refresh or all-bank precharge, and each request's class (hit, closed or conflict) and command gaps must match a bank model kept from the observed bus. Separately, a refresh taken while all four banks are open is judged on its precharge-all to refresh gap, its ready-return gap and the closed state it leaves.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_PREALL,
    CMD_REF
  } cmd_e;

  typedef struct packed {
    cmd_e cmd;
    logic latchReq;
    logic markOpen;
    logic closeBank;
    logic closeAll;
  } strobe_t;

endpackage

// File: rtl/rowbuf_ctrl.sv
module rowbuf_ctrl
  import rowbuf_pkg::*;
#(
  parameter int T_RP         = 2,
  parameter int T_RCD        = 2,
  parameter int T_RFC        = 4,
  parameter int REF_INTERVAL = 1000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  input  logic    pageHit,
  input  logic    bankBusy,
  input  logic    anyOpen,
  output strobe_t stb
);

  localparam int TMAX = (T_RP > T_RCD) ? ((T_RP > T_RFC) ? T_RP : T_RFC)
                                       : ((T_RCD > T_RFC) ? T_RCD : T_RFC);
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(REF_INTERVAL + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_WRP, ST_ACT, ST_WRCD, ST_COL,
    ST_PREALL, ST_WRPA, ST_REF, ST_WRFC
  } state_e;

  state_e        state, nxt;
  logic [TW-1:0] tmr;
  logic [RW-1:0] refCnt;
  logic          refPending;
  logic          wrLat;

  // sequencing decisions
  always_comb begin
    nxt = state;
    stb = '0;
    stb.cmd = CMD_NOP;
    case (state)
      ST_IDLE: begin
        if (refPending) begin
          nxt = anyOpen ? ST_PREALL : ST_REF;
        end else if (reqValid) begin
          stb.latchReq = 1'b1;
          nxt = pageHit ? ST_COL : (bankBusy ? ST_PRE : ST_ACT);
        end
      end
      ST_PRE:    begin stb.cmd = CMD_PRE; stb.closeBank = 1'b1; nxt = ST_WRP; end
      ST_WRP:    if (tmr == '0) nxt = ST_ACT;
      ST_ACT:    begin stb.cmd = CMD_ACT; stb.markOpen = 1'b1; nxt = ST_WRCD; end
      ST_WRCD:   if (tmr == '0) nxt = ST_COL;
      ST_COL:    begin stb.cmd = wrLat ? CMD_WR : CMD_RD; nxt = ST_IDLE; end
      ST_PREALL: begin stb.cmd = CMD_PREALL; stb.closeAll = 1'b1; nxt = ST_WRPA; end
      ST_WRPA:   if (tmr == '0) nxt = ST_REF;
      ST_REF:    begin stb.cmd = CMD_REF; nxt = ST_WRFC; end
      ST_WRFC:   if (tmr == '0) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE) && !refPending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tmr   <= '0;
      wrLat <= 1'b0;
    end else begin
      state <= nxt;
      if (stb.latchReq) wrLat <= reqWrite;
      case (state)
        ST_PRE, ST_PREALL: tmr <= TW'(T_RP - 2);
        ST_ACT:            tmr <= TW'(T_RCD - 2);
        ST_REF:            tmr <= TW'(T_RFC - 2);
        default:           if (tmr != '0) tmr <= tmr - 1'b1;
      endcase
    end
  end

  // refresh interval counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refCnt     <= '0;
      refPending <= 1'b0;
    end else begin
      if (refCnt == RW'(REF_INTERVAL - 1)) begin
        refCnt     <= '0;
        refPending <= 1'b1;
      end else begin
        refCnt <= refCnt + 1'b1;
        if (state == ST_REF) refPending <= 1'b0;
      end
    end
  end

  // gap checkers
  logic [7:0] sincePre, sinceAct, sinceRef;
  logic       inFlight;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sincePre <= 8'hFF;
      sinceAct <= 8'hFF;
      sinceRef <= 8'hFF;
      inFlight <= 1'b0;
    end else begin
      sincePre <= (stb.cmd == CMD_PRE || stb.cmd == CMD_PREALL) ? 8'd1
                : (sincePre == 8'hFF ? sincePre : sincePre + 8'd1);
      sinceAct <= (stb.cmd == CMD_ACT) ? 8'd1
                : (sinceAct == 8'hFF ? sinceAct : sinceAct + 8'd1);
      sinceRef <= (stb.cmd == CMD_REF) ? 8'd1
                : (sinceRef == 8'hFF ? sinceRef : sinceRef + 8'd1);
      if (stb.latchReq) inFlight <= 1'b1;
      else if (stb.cmd == CMD_RD || stb.cmd == CMD_WR) inFlight <= 1'b0;
    end
  end

  assert_pre_to_act_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.cmd == CMD_ACT || stb.cmd == CMD_REF) |-> (sincePre >= 8'(T_RP)));

  assert_act_to_col_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.cmd == CMD_RD || stb.cmd == CMD_WR) |-> (sinceAct >= 8'(T_RCD)));

  assert_ref_recovery_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.cmd != CMD_NOP) |-> (sinceRef >= 8'(T_RFC)));

  assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady);

  assert_no_refresh_midseq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.cmd == CMD_REF || stb.cmd == CMD_PREALL) |-> !inFlight);

endmodule

// File: rtl/rowbuf_dpath.sv
module rowbuf_dpath
  import rowbuf_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int BANK_W  = 2,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 16,
  parameter int CAS_LAT = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  strobe_t                        stb,
  input  logic [ROW_W+BANK_W+COL_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]              reqWdata,
  output logic                           pageHit,
  output logic                           bankBusy,
  output logic                           anyOpen,
  output logic                           sdRasN,
  output logic                           sdCasN,
  output logic                           sdWeN,
  output logic [BANK_W-1:0]              sdBank,
  output logic [ROW_W-1:0]               sdAddr,
  output logic [DATA_W-1:0]              sdWdata,
  input  logic [DATA_W-1:0]              sdRdata,
  output logic                           rspValid,
  output logic [DATA_W-1:0]              rspData
);

  localparam int ADDR_W = ROW_W + BANK_W + COL_W;
  localparam int NBANK  = 1 << BANK_W;
  localparam int AP_BIT = 10;

  logic [ROW_W-1:0]  reqRow, latRow;
  logic [BANK_W-1:0] reqBank, latBank;
  logic [COL_W-1:0]  latCol;
  logic [DATA_W-1:0] latData;

  assign reqRow  = reqAddr[ADDR_W-1 -: ROW_W];
  assign reqBank = reqAddr[COL_W +: BANK_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latRow  <= '0;
      latBank <= '0;
      latCol  <= '0;
      latData <= '0;
    end else if (stb.latchReq) begin
      latRow  <= reqRow;
      latBank <= reqBank;
      latCol  <= reqAddr[COL_W-1:0];
      latData <= reqWdata;
    end
  end

  // per-bank open-row table
  logic [NBANK-1:0] openVld;
  logic [ROW_W-1:0] openRow [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             vldQ, sel;
    logic [ROW_W-1:0] rowQ;
    assign sel = (latBank == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vldQ <= 1'b0;
        rowQ <= '0;
      end else if (stb.closeAll || (stb.closeBank && sel)) begin
        vldQ <= 1'b0;
      end else if (stb.markOpen && sel) begin
        vldQ <= 1'b1;
        rowQ <= latRow;
      end
    end
    assign openVld[b] = vldQ;
    assign openRow[b] = rowQ;
  end

  assign pageHit  = openVld[reqBank] && (openRow[reqBank] == reqRow);
  assign bankBusy = openVld[reqBank] && (openRow[reqBank] != reqRow);
  assign anyOpen  = |openVld;

  // command pins
  always_comb begin
    {sdRasN, sdCasN, sdWeN} = 3'b111;
    sdBank = '0;
    sdAddr = '0;
    case (stb.cmd)
      CMD_ACT:    begin {sdRasN, sdCasN, sdWeN} = 3'b011; sdBank = latBank; sdAddr = latRow; end
      CMD_RD:     begin {sdRasN, sdCasN, sdWeN} = 3'b101; sdBank = latBank; sdAddr = ROW_W'(latCol); end
      CMD_WR:     begin {sdRasN, sdCasN, sdWeN} = 3'b100; sdBank = latBank; sdAddr = ROW_W'(latCol); end
      CMD_PRE:    begin {sdRasN, sdCasN, sdWeN} = 3'b010; sdBank = latBank; end
      CMD_PREALL: begin {sdRasN, sdCasN, sdWeN} = 3'b010; sdAddr = ROW_W'(1) << AP_BIT; end
      CMD_REF:    {sdRasN, sdCasN, sdWeN} = 3'b001;
      default:    {sdRasN, sdCasN, sdWeN} = 3'b111;
    endcase
  end

  assign sdWdata = latData;

  // read return delay line
  logic [CAS_LAT-1:0] rdPipe;
  logic               rdIssue;
  assign rdIssue = (stb.cmd == CMD_RD);

  if (CAS_LAT == 1) begin : g_lat1
    always_ff @(posedge clk) begin
      if (!rst_n) rdPipe <= '0;
      else        rdPipe <= rdIssue;
    end
  end else begin : g_latn
    always_ff @(posedge clk) begin
      if (!rst_n) rdPipe <= '0;
      else        rdPipe <= {rdPipe[CAS_LAT-2:0], rdIssue};
    end
  end

  assign rspValid = rdPipe[CAS_LAT-1];
  assign rspData  = sdRdata;

  assert_act_on_closed_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.cmd == CMD_ACT) |-> !openVld[latBank]);

  assert_col_on_open_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.cmd == CMD_RD || stb.cmd == CMD_WR) |-> (openVld[latBank] && openRow[latBank] == latRow));

  assert_refresh_all_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.cmd == CMD_REF) |-> (openVld == '0));

  assert_act_marks_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.cmd == CMD_ACT) |=> openVld[$past(latBank)]);

endmodule

// File: rtl/rowbuf_sequencer.sv
module rowbuf_sequencer
  import rowbuf_pkg::*;
#(
  parameter int ROW_W        = 12,
  parameter int BANK_W       = 2,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 16,
  parameter int T_RP         = 2,
  parameter int T_RCD        = 2,
  parameter int CAS_LAT      = 3,
  parameter int T_RFC        = 4,
  parameter int REF_INTERVAL = 1000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic [ROW_W+BANK_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  output logic                          reqReady,
  output logic                          rspValid,
  output logic [DATA_W-1:0]             rspData,
  output logic                          sdRasN,
  output logic                          sdCasN,
  output logic                          sdWeN,
  output logic [BANK_W-1:0]             sdBank,
  output logic [ROW_W-1:0]              sdAddr,
  output logic [DATA_W-1:0]             sdWdata,
  input  logic [DATA_W-1:0]             sdRdata
);

  strobe_t stb;
  logic    pageHit, bankBusy, anyOpen;

  rowbuf_ctrl #(
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC), .REF_INTERVAL(REF_INTERVAL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .pageHit(pageHit), .bankBusy(bankBusy),
    .anyOpen(anyOpen), .stb(stb)
  );

  rowbuf_dpath #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W), .CAS_LAT(CAS_LAT)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .pageHit(pageHit), .bankBusy(bankBusy), .anyOpen(anyOpen),
    .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBank(sdBank),
    .sdAddr(sdAddr), .sdWdata(sdWdata), .sdRdata(sdRdata),
    .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: tb/tb_rowbuf_sequencer.sv
module tb_rowbuf_sequencer;

  localparam int T_RP = 2, T_RCD = 3, CAS_LAT = 3, T_RFC = 4, REF_INTERVAL = 400;
  localparam int CLS_HIT = 0, CLS_CLOSED = 1, CLS_CONFLICT = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [22:0] reqAddr = '0;
  logic [15:0] reqWdata = '0, sdRdata = '0;
  logic        reqReady, rspValid, sdRasN, sdCasN, sdWeN;
  logic [15:0] rspData, sdWdata;
  logic [1:0]  sdBank;
  logic [11:0] sdAddr;

  always #4 clk = ~clk;

  rowbuf_sequencer #(
    .T_RP(T_RP), .T_RCD(T_RCD), .CAS_LAT(CAS_LAT), .T_RFC(T_RFC), .REF_INTERVAL(REF_INTERVAL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBank(sdBank), .sdAddr(sdAddr),
    .sdWdata(sdWdata), .sdRdata(sdRdata)
  );

  // {write, row[12], bank[2], col[9], data[16], class[2]}
  localparam int NV = 12;
  localparam logic [41:0] VEC [NV] = '{
    {1'b1, 12'h0A1, 2'd0, 9'h010, 16'h1234, 2'd1},
    {1'b0, 12'h0A1, 2'd0, 9'h010, 16'hBEEF, 2'd0},
    {1'b1, 12'h0A1, 2'd0, 9'h1FF, 16'h5A5A, 2'd0},
    {1'b0, 12'h0B2, 2'd1, 9'h000, 16'h0F0F, 2'd1},
    {1'b1, 12'h0B3, 2'd1, 9'h005, 16'hC3C3, 2'd2},
    {1'b0, 12'h0A1, 2'd0, 9'h020, 16'h7777, 2'd0},
    {1'b0, 12'h005, 2'd0, 9'h020, 16'h1111, 2'd2},
    {1'b1, 12'hFFF, 2'd3, 9'h1FF, 16'hFFFF, 2'd1},
    {1'b0, 12'hFFF, 2'd3, 9'h000, 16'h8001, 2'd0},
    {1'b1, 12'h000, 2'd2, 9'h000, 16'h0000, 2'd1},
    {1'b0, 12'h0A1, 2'd0, 9'h001, 16'h2468, 2'd2},
    {1'b0, 12'h0B3, 2'd1, 9'h005, 16'h1357, 2'd0}
  };

  int  cyc = 0, checks = 0, fails = 0;
  int  refCount = 0, lastRefCyc = -1, lastPreAllCyc = -1;
  int  preC, actC, colC, preBankS, preA10S, actBankS, actRowS, colBankS, colAddrS, colWrS, wdS;
  bit  readyAtRef;
  bit  done = 1'b0;
  bit        mVld [4];
  logic [11:0] mRow [4];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: advance to the falling edge and decode the bus (R2 encoding)
  task automatic tick();
    @(negedge clk);
    cyc++;
    case ({sdRasN, sdCasN, sdWeN})
      3'b010: if (sdAddr[10]) begin
                lastPreAllCyc = cyc;
                for (int b = 0; b < 4; b++) mVld[b] = 1'b0;
              end else begin
                preC = cyc; preBankS = sdBank; preA10S = sdAddr[10];
                mVld[sdBank] = 1'b0;
              end
      3'b011: begin actC = cyc; actBankS = sdBank; actRowS = sdAddr;
                mVld[sdBank] = 1'b1; mRow[sdBank] = sdAddr; end
      3'b101, 3'b100: begin colC = cyc; colBankS = sdBank; colAddrS = sdAddr;
                colWrS = !sdWeN; wdS = sdWdata; end
      3'b001: begin refCount++; lastRefCyc = cyc; readyAtRef = reqReady; end
      default: ;
    endcase
  endtask

  task automatic doReq(input bit w, input logic [22:0] a, input logic [15:0] d, input int cls);
    int acc, refAtAcc, expCls, n;
    logic [1:0] bk;
    logic [11:0] rw;
    bk = a[10:9]; rw = a[22:11];
    n = 0;
    while (!reqReady && n < 100) begin tick(); n++; end
    expCls = (cls >= 0) ? cls : (!mVld[bk] ? CLS_CLOSED : (mRow[bk] == rw ? CLS_HIT : CLS_CONFLICT));
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    acc = cyc; refAtAcc = refCount;
    preC = -1; actC = -1; colC = -1;
    tick();
    reqValid = 1'b0;
    chk(!reqReady, "R9", "ready after accept", reqReady, 0);
    n = 0;
    while (colC < 0 && n < 40) begin tick(); n++; end
    chk(colC >= 0, "R2", "column command seen", colC, 1);
    if (expCls == CLS_HIT) begin
      chk(preC < 0 && actC < 0, "R5", "hit issues no pre/act", (preC >= 0) | ((actC >= 0) << 1), 0);
      chk(colC == acc + 1, "R5", "hit column cycle", colC - acc, 1);
    end else if (expCls == CLS_CLOSED) begin
      chk(preC < 0, "R3", "closed bank has no precharge", preC, -1);
      chk(actC == acc + 1, "R3", "activate cycle", actC - acc, 1);
      chk(colC == actC + T_RCD, "R3", "act to column gap", colC - actC, T_RCD);
    end else begin
      chk(preC == acc + 1, "R4", "precharge cycle", preC - acc, 1);
      chk(preBankS == bk && preA10S == 0, "R4", "precharge single bank", {preA10S, preBankS}, bk);
      chk(actC == preC + T_RP, "R4", "pre to act gap", actC - preC, T_RP);
      chk(colC == actC + T_RCD, "R4", "act to column gap", colC - actC, T_RCD);
    end
    if (actC >= 0) chk(actRowS == rw && actBankS == bk, "R1", "activate row/bank", {actBankS, actRowS}, {bk, rw});
    chk(colAddrS[8:0] == a[8:0] && colAddrS[10] == 0 && colBankS == bk, "R1", "column addr/bank",
        colAddrS | (colBankS << 12), {bk, 3'b000, a[8:0]});
    chk(colWrS == w, "R2", "read/write encoding", colWrS, w);
    chk(refCount == refAtAcc, "R11", "no refresh inside sequence", refCount - refAtAcc, 0);
    if (w) begin
      chk(wdS == d, "R7", "write data on bus", wdS, d);
    end else begin
      sdRdata = d;
      for (int k = 1; k <= CAS_LAT; k++) begin
        tick();
        if (k < CAS_LAT) begin
          if (rspValid) chk(1'b0, "R6", "early rspValid", k, CAS_LAT);
        end else begin
          chk(rspValid, "R6", "rspValid at CAS latency", rspValid, 1);
          chk(rspData == d, "R6", "read data", rspData, d);
        end
      end
      tick();
      chk(!rspValid, "R6", "rspValid single cycle", rspValid, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int r0, n;
    for (int b = 0; b < 4; b++) begin mVld[b] = 1'b0; mRow[b] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk({sdRasN, sdCasN, sdWeN} == 3'b111, "R10", "bus idle after reset", {sdRasN, sdCasN, sdWeN}, 3'b111);
    chk(reqReady, "R10", "ready after reset", reqReady, 1);
    chk(!rspValid, "R10", "no response after reset", rspValid, 0);

    // table of vectors
    for (int i = 0; i < NV; i++)
      doReq(VEC[i][41], VEC[i][40:18], VEC[i][17:2], int'(VEC[i][1:0]));

    // R8: refresh with all four banks open
    r0 = refCount; lastPreAllCyc = -1; n = 0;
    while (refCount == r0 && n < 600) begin tick(); n++; end
    chk(refCount > r0, "R8", "refresh issued", refCount - r0, 1);
    chk(lastPreAllCyc >= 0 && lastRefCyc == lastPreAllCyc + T_RP, "R8", "precharge-all to refresh gap",
        lastRefCyc - lastPreAllCyc, T_RP);
    chk(!readyAtRef, "R9", "ready low during refresh", readyAtRef, 0);
    n = 0;
    while (!reqReady && n < 20) begin tick(); n++; end
    chk(cyc == lastRefCyc + T_RFC, "R8", "ready returns after refresh", cyc - lastRefCyc, T_RFC);
    doReq(1'b0, {12'h0B3, 2'd1, 9'h005}, 16'h4242, CLS_CLOSED); // R8 bank closed after refresh

    // R11: stream conflicts across the next refresh expiry
    r0 = refCount;
    for (int i = 0; i < 60; i++)
      doReq(1'b1, {12'(i[0] ? 12'h123 : 12'h456), 2'd2, 9'(i)}, 16'(i * 7), -1);
    chk(refCount > r0, "R11", "refresh taken during request stream", refCount - r0, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule